// File: doc/BRIEF.md
# Indexed Configuration Port with Two-Wire Bus Port Multiplexer

This block gives a host a narrow two-address window onto a bank of byte-wide configuration registers. The host first writes a register number to the low address, then reads or writes the high address, which always acts on the register last named. A few registers in the bank control a two-wire serial bus master. One bit enables the master. Two bytes hold its I/O base address. A two-bit field, kept in one of two candidate registers, picks which of four downstream port pin pairs the master is connected to.

The master drives its clock and data lines through active-low open-drain enables. The block routes those enables to the chosen port and returns that port's sensed pin levels to the master. Every other port stays released.

A new port choice never cuts into a transfer in progress. While the master reports busy, the connected port is frozen. The pending choice is applied on the first idle cycle.

Top module: `cfg_port_mux`

## Requirements
- R1: A write with `acc_addr` = 0 loads `acc_wdata` into the index register at the next clock edge. With `acc_addr` = 0, `acc_rdata` shows the index register.
- R2: A write with `acc_addr` = 1 stores `acc_wdata` into the bank entry named by the index. With `acc_addr` = 1, `acc_rdata` shows that entry. Indexes at or above `REG_COUNT` (default 64) read as 0x00, and writes to them change nothing.
- R3: The requested port is bits 2:1 of register 0x2E when bit 0 of register 0x2F is 1, and bits 2:1 of register 0x2C when that bit is 0.
- R4: When `master_busy` is low at a clock edge, `active_port` takes the port requested before that edge.
- R5: When `master_busy` is high at a clock edge, `active_port` keeps its value.
- R6: While the controller is enabled, bit p of `port_scl_oe` and `port_sda_oe` equals the master's enable for p = `active_port` and is 0 for every other port. `m_scl_in` and `m_sda_in` carry the pin levels of port `active_port`.
- R7: `ctrl_en` is bit 0 of register 0x2C. While it is 0, all port enables are 0 and `m_scl_in` and `m_sda_in` read 1.
- R8: `io_base` equals {register 0x2D, register 0x2C} ANDed with 0xFFE0.
- R9: Reset clears the index, every bank entry and `active_port`. After reset, port 0 is chosen, the controller is disabled and `io_base` is 0.
- R10: The host can change the select field by reading register 0x2C, replacing bits 2:1 and writing the byte back. This read-modify-write leaves the enable bit and the base address bits as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Host access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 1 | 0 = index address, 1 = data address |
| acc_wdata | input | 8 | Host write byte |
| acc_rdata | output | 8 | Host read byte |
| master_busy | input | 1 | Bus master transfer in progress |
| m_scl_oe | input | 1 | Master clock-line pull-low enable |
| m_sda_oe | input | 1 | Master data-line pull-low enable |
| m_scl_in | output | 1 | Sensed clock level of the connected port |
| m_sda_in | output | 1 | Sensed data level of the connected port |
| port_scl_oe | output | 4 | Per-port clock pull-low enables |
| port_sda_oe | output | 4 | Per-port data pull-low enables |
| port_scl_in | input | 4 | Per-port sensed clock levels |
| port_sda_in | input | 4 | Per-port sensed data levels |
| ctrl_en | output | 1 | Controller enable bit |
| io_base | output | 16 | Masked I/O base address |
| active_port | output | 2 | Port currently connected to the master |

## Verification
Two functions can land on the same clock edge: a host data write that changes the select field, and the busy-to-idle transition that lets the connected port move. The bench provokes this by lowering `master_busy` in the very cycle that a new select byte is written. It expects the port to take the value requested before the edge, and to take the newly written field only one edge later. A behavioural reference model follows every edge and checks this cycle by cycle. It also checks a long stretch of random accesses with random busy patterns and random pin levels.

// File: rtl/cfgmux_pkg.sv
package cfgmux_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] SEL_PRI_IDX  = 8'h2C;
  localparam logic [BYTE_W-1:0] BASE_HI_IDX  = 8'h2D;
  localparam logic [BYTE_W-1:0] SEL_ALT_IDX  = 8'h2E;
  localparam logic [BYTE_W-1:0] SRC_MODE_IDX = 8'h2F;
  localparam int SEL_LSB = 1;
  localparam int ENABLE_BIT = 0;
  localparam int SRC_BIT = 0;
  localparam logic [2*BYTE_W-1:0] BASE_MASK = 16'hFFE0;

  function automatic logic [2*BYTE_W-1:0] calc_io_base(input logic [BYTE_W-1:0] lo,
                                                       input logic [BYTE_W-1:0] hi);
    return {hi, lo} & BASE_MASK;
  endfunction
endpackage

// File: rtl/cfg_index_regs.sv
module cfg_index_regs
  import cfgmux_pkg::*;
#(
  parameter int REG_COUNT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_addr,
  input  logic [BYTE_W-1:0] acc_wdata,
  output logic [BYTE_W-1:0] acc_rdata,
  output logic [BYTE_W-1:0] reg_pri,
  output logic [BYTE_W-1:0] reg_hi,
  output logic [BYTE_W-1:0] reg_alt,
  output logic [BYTE_W-1:0] reg_mode
);
  localparam int AW = $clog2(REG_COUNT);

  logic [BYTE_W-1:0] idx_q;
  logic [BYTE_W-1:0] bank_q [REG_COUNT];
  logic              idx_wr;
  logic              data_wr;
  logic              idx_hit;
  logic [AW-1:0]     slot;

  assign idx_wr  = acc_valid && acc_write && !acc_addr;
  assign data_wr = acc_valid && acc_write && acc_addr;
  assign idx_hit = (int'(idx_q) < REG_COUNT);
  assign slot    = idx_q[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_wr) begin
      idx_q <= acc_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_COUNT; i++) bank_q[i] <= '0;
    end else if (data_wr && idx_hit) begin
      bank_q[slot] <= acc_wdata;
    end
  end

  always_comb begin
    if (acc_addr) acc_rdata = idx_hit ? bank_q[slot] : '0;
    else          acc_rdata = idx_q;
  end

  assign reg_pri  = bank_q[SEL_PRI_IDX[AW-1:0]];
  assign reg_hi   = bank_q[BASE_HI_IDX[AW-1:0]];
  assign reg_alt  = bank_q[SEL_ALT_IDX[AW-1:0]];
  assign reg_mode = bank_q[SRC_MODE_IDX[AW-1:0]];

  AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> idx_q == $past(acc_wdata)); // R1
  AST_SELECT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && idx_q == SEL_PRI_IDX) |=> reg_pri == $past(acc_wdata)); // R2
  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !idx_hit) |=> ($stable(reg_pri) && $stable(reg_hi) && $stable(reg_alt) && $stable(reg_mode))); // R2
endmodule

// File: rtl/port_sel_ctrl.sv
module port_sel_ctrl
  import cfgmux_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] reg_pri,
  input  logic [BYTE_W-1:0] reg_alt,
  input  logic [BYTE_W-1:0] reg_mode,
  input  logic              master_busy,
  output logic [SEL_W-1:0]  req_sel,
  output logic [SEL_W-1:0]  active_sel
);
  logic              use_alt;
  logic [SEL_W-1:0]  active_q;

  assign use_alt = reg_mode[SRC_BIT];
  assign req_sel = use_alt ? reg_alt[SEL_LSB +: SEL_W] : reg_pri[SEL_LSB +: SEL_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= '0;
    end else if (!master_busy) begin
      active_q <= req_sel;
    end
  end

  assign active_sel = active_q;

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    master_busy |=> $stable(active_sel)); // R5
  AST_FOLLOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !master_busy |=> active_sel == $past(req_sel)); // R4
endmodule

// File: rtl/pin_route.sv
module pin_route #(
  parameter int PORT_COUNT = 4,
  parameter int SEL_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  route_en,
  input  logic [SEL_W-1:0]      active_sel,
  input  logic                  m_scl_oe,
  input  logic                  m_sda_oe,
  output logic                  m_scl_in,
  output logic                  m_sda_in,
  output logic [PORT_COUNT-1:0] port_scl_oe,
  output logic [PORT_COUNT-1:0] port_sda_oe,
  input  logic [PORT_COUNT-1:0] port_scl_in,
  input  logic [PORT_COUNT-1:0] port_sda_in
);
  logic [PORT_COUNT-1:0] pick;

  for (genvar p = 0; p < PORT_COUNT; p++) begin : g_port
    assign pick[p]        = route_en && (active_sel == SEL_W'(p));
    assign port_scl_oe[p] = pick[p] & m_scl_oe;
    assign port_sda_oe[p] = pick[p] & m_sda_oe;
  end

  always_comb begin
    m_scl_in = 1'b1;
    m_sda_in = 1'b1;
    if (route_en) begin
      m_scl_in = port_scl_in[active_sel];
      m_sda_in = port_sda_in[active_sel];
    end
  end

  AST_SINGLE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(port_scl_oe) && $onehot0(port_sda_oe)); // R6
  AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !route_en |-> (port_scl_oe == '0 && port_sda_oe == '0 && m_scl_in && m_sda_in)); // R7
endmodule

// File: rtl/cfg_port_mux.sv
module cfg_port_mux
  import cfgmux_pkg::*;
#(
  parameter int REG_COUNT  = 64,
  parameter int PORT_COUNT = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid,
  input  logic                  acc_write,
  input  logic                  acc_addr,
  input  logic [7:0]            acc_wdata,
  output logic [7:0]            acc_rdata,
  input  logic                  master_busy,
  input  logic                  m_scl_oe,
  input  logic                  m_sda_oe,
  output logic                  m_scl_in,
  output logic                  m_sda_in,
  output logic [PORT_COUNT-1:0] port_scl_oe,
  output logic [PORT_COUNT-1:0] port_sda_oe,
  input  logic [PORT_COUNT-1:0] port_scl_in,
  input  logic [PORT_COUNT-1:0] port_sda_in,
  output logic                  ctrl_en,
  output logic [15:0]           io_base,
  output logic [1:0]            active_port
);
  localparam int SEL_W = $clog2(PORT_COUNT);

  logic [BYTE_W-1:0] reg_pri;
  logic [BYTE_W-1:0] reg_hi;
  logic [BYTE_W-1:0] reg_alt;
  logic [BYTE_W-1:0] reg_mode;
  logic [SEL_W-1:0]  req_sel;
  logic [SEL_W-1:0]  active_sel;

  cfg_index_regs #(.REG_COUNT(REG_COUNT)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .reg_pri(reg_pri), .reg_hi(reg_hi), .reg_alt(reg_alt), .reg_mode(reg_mode)
  );

  port_sel_ctrl #(.SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst_n(rst_n),
    .reg_pri(reg_pri), .reg_alt(reg_alt), .reg_mode(reg_mode),
    .master_busy(master_busy), .req_sel(req_sel), .active_sel(active_sel)
  );

  assign ctrl_en     = reg_pri[ENABLE_BIT];
  assign io_base     = calc_io_base(reg_pri, reg_hi);
  assign active_port = 2'(active_sel);

  pin_route #(.PORT_COUNT(PORT_COUNT), .SEL_W(SEL_W)) u_route (
    .clk(clk), .rst_n(rst_n),
    .route_en(ctrl_en), .active_sel(active_sel),
    .m_scl_oe(m_scl_oe), .m_sda_oe(m_sda_oe),
    .m_scl_in(m_scl_in), .m_sda_in(m_sda_in),
    .port_scl_oe(port_scl_oe), .port_sda_oe(port_sda_oe),
    .port_scl_in(port_scl_in), .port_sda_in(port_sda_in)
  );

  AST_BASE_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    io_base[4:0] == 5'd0); // R8
  AST_RESET_PORT0: assert property (@(posedge clk)
    !rst_n |=> (active_port == 2'd0 && !ctrl_en)); // R9
endmodule

// File: tb/cfg_port_mux_tb.sv
module cfg_port_mux_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0, acc_write = 1'b0, acc_addr = 1'b0;
  logic [7:0] acc_wdata = 8'h00;
  logic [7:0] acc_rdata;
  logic       master_busy = 1'b0;
  logic       m_scl_oe = 1'b0, m_sda_oe = 1'b0;
  logic       m_scl_in, m_sda_in;
  logic [3:0] port_scl_oe, port_sda_oe;
  logic [3:0] port_scl_in = 4'hF, port_sda_in = 4'hF;
  logic       ctrl_en;
  logic [15:0] io_base;
  logic [1:0] active_port;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state
  logic [7:0] m_reg [0:63];
  int         m_idx = 0;
  int         m_act = 0;
  bit         last_busy = 1'b0;

  always #2.5 clk = ~clk;

  cfg_port_mux dut_i (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .master_busy(master_busy), .m_scl_oe(m_scl_oe), .m_sda_oe(m_sda_oe),
    .m_scl_in(m_scl_in), .m_sda_in(m_sda_in),
    .port_scl_oe(port_scl_oe), .port_sda_oe(port_sda_oe),
    .port_scl_in(port_scl_in), .port_sda_in(port_sda_in),
    .ctrl_en(ctrl_en), .io_base(io_base), .active_port(active_port)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int req_port();
    logic [7:0] src;
    src = m_reg[8'h2F][0] ? m_reg[8'h2E] : m_reg[8'h2C];
    return (int'(src) / 2) % 4;
  endfunction

  task automatic compare_all();
    logic [7:0] exp_rd;
    bit en;
    en = m_reg[8'h2C][0];
    if (acc_addr) exp_rd = (m_idx < 64) ? m_reg[m_idx] : 8'h00;
    else          exp_rd = 8'(m_idx);
    chk(16'(acc_rdata), 16'(exp_rd), acc_addr ? "R2 data read" : "R1 index read");
    chk(16'(ctrl_en), 16'(en), "R7 enable bit");
    chk(io_base, {m_reg[8'h2D], m_reg[8'h2C]} & 16'hFFE0, "R8 base");
    chk(16'(active_port), 16'(m_act), last_busy ? "R5 held port" : "R4 followed port");
    chk(16'(port_scl_oe), en ? 16'(m_scl_oe) << m_act : 16'h0, "R6 scl enables");
    chk(16'(port_sda_oe), en ? 16'(m_sda_oe) << m_act : 16'h0, "R6 sda enables");
    chk(16'(m_scl_in), en ? 16'(port_scl_in[m_act]) : 16'h1, "R6 scl return");
    chk(16'(m_sda_in), en ? 16'(port_sda_in[m_act]) : 16'h1, "R6 sda return");
  endtask

  // one clock: inputs already set at negedge, compare, edge, update model
  task automatic cycle(input bit v, input bit w, input bit a, input logic [7:0] d);
    int req;
    acc_valid = v; acc_write = w; acc_addr = a; acc_wdata = d;
    m_scl_oe = 1'($urandom); m_sda_oe = 1'($urandom);
    port_scl_in = 4'($urandom); port_sda_in = 4'($urandom);
    #1;
    compare_all();
    @(posedge clk);
    req = req_port();
    if (v && w) begin
      if (!a) m_idx = int'(d);
      else if (m_idx < 64) m_reg[m_idx] = d;
    end
    if (!master_busy) m_act = req;
    last_busy = master_busy;
    @(negedge clk);
  endtask

  task automatic wr(input bit a, input logic [7:0] d);
    cycle(1'b1, 1'b1, a, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic peek(input bit a);
    acc_valid = 1'b0; acc_write = 1'b0; acc_addr = a;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] orig;
    for (int i = 0; i < 64; i++) m_reg[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    m_scl_oe = 1'b1; m_sda_oe = 1'b1;
    peek(1'b0);
    chk(16'(acc_rdata), 16'h0, "R9 index after reset");
    chk(16'(active_port), 16'h0, "R9 port after reset");
    chk(16'(ctrl_en), 16'h0, "R9 disabled after reset");
    chk(io_base, 16'h0, "R9 base after reset");
    chk(16'(port_scl_oe | port_sda_oe), 16'h0, "R9 ports released");

    // enable, base, primary select = 2
    wr(1'b0, 8'h2D); wr(1'b1, 8'h12);
    wr(1'b0, 8'h2C); wr(1'b1, 8'hE5);
    idle(2);
    chk(16'(active_port), 16'd2, "R3 primary source");
    chk(io_base, 16'h12E0, "R8 masked base");

    // alternate source = 1
    wr(1'b0, 8'h2E); wr(1'b1, 8'h02);
    wr(1'b0, 8'h2F); wr(1'b1, 8'h01);
    idle(2);
    chk(16'(active_port), 16'd1, "R3 alternate source");
    wr(1'b1, 8'h00);
    idle(2);
    chk(16'(active_port), 16'd2, "R3 back to primary");

    // busy hold
    master_busy = 1'b1;
    wr(1'b0, 8'h2C); wr(1'b1, 8'hE7);
    idle(3);
    chk(16'(active_port), 16'd2, "R5 frozen while busy");
    master_busy = 1'b0;
    idle(1);
    chk(16'(active_port), 16'd3, "R5 applied on first idle");

    // busy falls in the same cycle as a select write
    master_busy = 1'b1;
    idle(1);
    master_busy = 1'b0;
    wr(1'b1, 8'hE1);
    chk(16'(active_port), 16'd3, "R4 pre-edge request taken");
    idle(1);
    chk(16'(active_port), 16'd0, "R4 new request one edge later");

    // in-range and unmapped indexes
    wr(1'b0, 8'h10); wr(1'b1, 8'h5A);
    peek(1'b1);
    chk(16'(acc_rdata), 16'h5A, "R2 mapped readback");
    wr(1'b0, 8'h50); wr(1'b1, 8'hAA);
    peek(1'b1);
    chk(16'(acc_rdata), 16'h00, "R2 unmapped reads zero");
    peek(1'b0);
    chk(16'(acc_rdata), 16'h50, "R1 index readback");
    wr(1'b0, 8'h10);
    peek(1'b1);
    chk(16'(acc_rdata), 16'h5A, "R2 unmapped write ignored");

    // read-modify-write of select field
    wr(1'b0, 8'h2C);
    peek(1'b1);
    orig = acc_rdata;
    wr(1'b1, (orig & 8'hF9) | 8'h04);
    peek(1'b1);
    chk(16'(acc_rdata), 16'((orig & 8'hF9) | 8'h04), "R10 other bits kept");
    chk(16'(ctrl_en), 16'h1, "R10 enable kept");
    chk(io_base, 16'h12E0, "R10 base kept");
    idle(2);
    chk(16'(active_port), 16'd2, "R10 new field applied");

    // disable releases everything
    wr(1'b1, 8'h06);
    idle(2);
    m_scl_oe = 1'b1; m_sda_oe = 1'b1; port_scl_in = 4'h0; port_sda_in = 4'h0;
    #1;
    chk(16'(port_scl_oe | port_sda_oe), 16'h0, "R7 disabled ports released");
    chk(16'({m_scl_in, m_sda_in}), 16'h3, "R7 disabled returns high");
    wr(1'b1, 8'h07);

    // random phase
    for (int n = 0; n < 600; n++) begin
      logic [7:0] pick_idx;
      int r;
      master_busy = ($urandom % 3) == 0;
      r = $urandom % 6;
      case ($urandom % 5)
        0: pick_idx = 8'h2C;
        1: pick_idx = 8'h2D;
        2: pick_idx = 8'h2E;
        3: pick_idx = 8'h2F;
        default: pick_idx = 8'($urandom);
      endcase
      if (r == 0)      wr(1'b0, pick_idx);
      else if (r < 3)  wr(1'b1, 8'($urandom) | 8'h01);
      else if (r == 3) cycle(1'b1, 1'b0, 1'($urandom), 8'h00);
      else             idle(1);
    end
    master_busy = 1'b0;
    idle(3);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule